// File: doc/BRIEF.md
# Interrupt Pending Register and Request Arbiter

This block keeps the interrupt state of a serial bus peripheral and decides which of its service requests goes first. Three pending bits record an error condition, a received byte and transmitter readiness. Software reads these bits through a byte-wide register port and can only clear them. The same register holds a three-bit priority level, which travels with the interrupt request to the system interrupt controller.

Each cycle the block ranks five sources in a fixed order: the error interrupt, the receiver DMA request, the transmitter DMA request, the receive interrupt and the transmit-ready interrupt. The DMA-stop mode input decides where the error interrupt sits in that order. A one-hot grant names the winner. The error pending bit stays pinned at 1 while any error flag from the protocol engine is active, so a software clear only takes effect once all the flags have dropped.

Top module: `isr_prio_arb`

## Requirements
- R1: After reset, `rd_data` reads 0xF0: bit 7 = 1, priority level (bits 6:4) = 7, bit 3 = 0, pending bits 2:0 = 0. Bit 7 always reads 1 and bit 3 always reads 0.
- R2: A write loads bits 6:4 of `wr_data` into the priority level. Bits 7 and 3 of the write data have no effect on what is read back.
- R3: In a cycle with `int_en` = 1, a strobe on `ev_err`, `ev_rx` or `ev_tx` sets pending bit 2, 1 or 0, and `rd_data` shows the new value after that clock edge. With `int_en` = 0 the strobes change nothing.
- R4: A write with a 0 in bit 2, 1 or 0 clears that pending bit. A 1 in that position leaves the bit as it was, so a write never sets a pending bit.
- R5: In every cycle with any `err_flags` bit high, pending bit 2 becomes 1 regardless of `int_en`, and a clear written in that cycle is lost.
- R6: When a set strobe (enabled) and a clearing write hit the same pending bit in the same cycle, the bit ends up 1.
- R7: One edge after the state is sampled, `irq` = (any pending bit is 1) and (level != 7), and `irq_level` equals the level.
- R8: `grant` bit positions are: 0 error interrupt (pending bit 2), 1 `dma_rx_req`, 2 `dma_tx_req`, 3 receive interrupt (pending bit 1), 4 transmit-ready interrupt (pending bit 0). With `dma_stop` = 1 the order from highest to lowest is 0, 1, 2, 3, 4.
- R9: With `dma_stop` = 0 the order from highest to lowest is 1, 2, 0, 3, 4.
- R10: `grant` is one-hot when any source is active and all zeros otherwise. It is registered from the pending state and DMA inputs seen at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| ev_err | input | 1 | Error event strobe |
| ev_rx | input | 1 | Byte received strobe |
| ev_tx | input | 1 | Ready to transmit strobe |
| int_en | input | 1 | Interrupt enable; gates the event strobes |
| err_flags | input | NUM_ERR_FLAGS | Error flags from the protocol engine |
| dma_rx_req | input | 1 | Receiver DMA request |
| dma_tx_req | input | 1 | Transmitter DMA request |
| dma_stop | input | 1 | Selects where the error interrupt ranks |
| irq | output | 1 | Interrupt request |
| irq_level | output | 3 | Priority level sent with the request |
| grant | output | 5 | One-hot winning source |

## Verification
The register view in `rd_data` changes at the edge that samples a write, event or error flag. `irq`, `irq_level` and `grant` come one edge later, because they are registered from the pending state held before that edge and from the DMA inputs sampled at that edge. For each cycle the bench computes its expectation from its own model as it stood before the edge, drives the inputs at the falling edge and samples just after the rising edge. In this way the register-view check and the arbitration check of each cycle use the correct model generations.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int PEND_W   = 3;
  localparam int LVL_W    = 3;
  localparam int NSRC     = 5;
  localparam int REG_W    = 8;
  // pending bit positions in the register
  localparam int P_TX     = 0;
  localparam int P_RX     = 1;
  localparam int P_ERR    = 2;
  localparam int LVL_LSB  = 4;
  // grant positions
  localparam int G_ERR    = 0;
  localparam int G_DRX    = 1;
  localparam int G_DTX    = 2;
  localparam int G_IRX    = 3;
  localparam int G_ITX    = 4;
  localparam logic [LVL_W-1:0] LVL_NONE = '1;

  // source at a given rank (0 = highest) for the selected mode
  function automatic int src_at_rank(input int rank, input logic stop);
    int s;
    s = rank;
    if (!stop) begin
      case (rank)
        0: s = G_DRX;
        1: s = G_DTX;
        2: s = G_ERR;
        default: s = rank;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/isr_pend_bit.sv
module isr_pend_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic force_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)                  q <= 1'b0;
    else if (set_i || force_i) q <= 1'b1;
    else if (clr_i)           q <= 1'b0;
  end
endmodule

// File: rtl/isr_src_arb.sv
module isr_src_arb
  import isr_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         stop,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    logic found;
    int   s;
    gnt   = '0;
    found = 1'b0;
    for (int r = 0; r < N; r++) begin
      s = src_at_rank(r, stop);
      if (!found && req[s]) begin
        gnt[s] = 1'b1;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/isr_prio_arb.sv
module isr_prio_arb
  import isr_pkg::*;
#(
  parameter int NUM_ERR_FLAGS = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [REG_W-1:0]         wr_data,
  output logic [REG_W-1:0]         rd_data,
  input  logic                     ev_err,
  input  logic                     ev_rx,
  input  logic                     ev_tx,
  input  logic                     int_en,
  input  logic [NUM_ERR_FLAGS-1:0] err_flags,
  input  logic                     dma_rx_req,
  input  logic                     dma_tx_req,
  input  logic                     dma_stop,
  output logic                     irq,
  output logic [LVL_W-1:0]         irq_level,
  output logic [NSRC-1:0]          grant
);
  logic [PEND_W-1:0] pend_q;
  logic [PEND_W-1:0] ev_vec;
  logic [LVL_W-1:0]  lvl_q;
  logic [NSRC-1:0]   req_vec;
  logic [NSRC-1:0]   gnt_c;
  logic              flag_any;

  assign ev_vec   = {ev_err, ev_rx, ev_tx};
  assign flag_any = |err_flags;

  genvar gi;
  generate
    for (gi = 0; gi < PEND_W; gi++) begin : g_pend
      isr_pend_bit u_bit (
        .clk     (clk),
        .rst     (rst),
        .set_i   (ev_vec[gi] && int_en),
        .force_i ((gi == P_ERR) ? flag_any : 1'b0),
        .clr_i   (wr_en && !wr_data[gi]),
        .q       (pend_q[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        lvl_q <= LVL_NONE;
    else if (wr_en) lvl_q <= wr_data[LVL_LSB +: LVL_W];
  end

  assign rd_data = {1'b1, lvl_q, 1'b0, pend_q};

  always_comb begin
    req_vec        = '0;
    req_vec[G_ERR] = pend_q[P_ERR];
    req_vec[G_DRX] = dma_rx_req;
    req_vec[G_DTX] = dma_tx_req;
    req_vec[G_IRX] = pend_q[P_RX];
    req_vec[G_ITX] = pend_q[P_TX];
  end

  isr_src_arb #(.N(NSRC)) u_arb (
    .stop (dma_stop),
    .req  (req_vec),
    .gnt  (gnt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      irq_level <= LVL_NONE;
      grant     <= '0;
    end else begin
      irq       <= (|pend_q) && (lvl_q != LVL_NONE);
      irq_level <= lvl_q;
      grant     <= gnt_c;
    end
  end
endmodule

// File: rtl/isr_prio_arb_chk.sv
module isr_prio_arb_chk
  import isr_pkg::*;
#(
  parameter int NUM_ERR_FLAGS = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic [REG_W-1:0]         wr_data,
  input logic [REG_W-1:0]         rd_data,
  input logic                     ev_err,
  input logic                     ev_rx,
  input logic                     ev_tx,
  input logic                     int_en,
  input logic [NUM_ERR_FLAGS-1:0] err_flags,
  input logic                     irq,
  input logic [LVL_W-1:0]         irq_level,
  input logic [NSRC-1:0]          grant
);
  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
    rd_data[7] && !rd_data[3]); // R1
  AST_RX_NO_SW_SET: assert property (@(posedge clk) disable iff (rst)
    !rd_data[P_RX] && !(ev_rx && int_en) |=> !rd_data[P_RX]); // R3
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (rst)
    wr_en && !wr_data[P_RX] && !(ev_rx && int_en) |=> !rd_data[P_RX]); // R4
  AST_ERR_PINNED: assert property (@(posedge clk) disable iff (rst)
    (|err_flags) |=> rd_data[P_ERR]); // R5
  AST_TX_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    ev_tx && int_en |=> rd_data[P_TX]); // R6
  AST_IRQ_LVL_NONE: assert property (@(posedge clk) disable iff (rst)
    irq_level == LVL_NONE |-> !irq); // R7
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R10
endmodule

bind isr_prio_arb isr_prio_arb_chk #(.NUM_ERR_FLAGS(NUM_ERR_FLAGS)) u_chk (.*);

// File: tb/isr_prio_arb_bench.sv
module isr_prio_arb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic ev_err = 1'b0, ev_rx = 1'b0, ev_tx = 1'b0, int_en = 1'b0;
  logic [NF-1:0] err_flags = '0;
  logic dma_rx_req = 1'b0, dma_tx_req = 1'b0, dma_stop = 1'b0;
  logic irq;
  logic [2:0] irq_level;
  logic [4:0] grant;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;
  logic [2:0] m_pend = '0;
  logic [2:0] m_lvl = 3'd7;

  always #(CLK_PERIOD/2) clk = ~clk;

  isr_prio_arb #(.NUM_ERR_FLAGS(NF)) u_isr_prio_arb (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ev_err(ev_err), .ev_rx(ev_rx), .ev_tx(ev_tx), .int_en(int_en),
    .err_flags(err_flags), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req),
    .dma_stop(dma_stop), .irq(irq), .irq_level(irq_level), .grant(grant)
  );

  // expected grant: bit0 err, bit1 dma rx, bit2 dma tx, bit3 rx int, bit4 tx int
  function automatic logic [4:0] exp_grant(input logic [2:0] p, input logic drx,
                                           input logic dtx, input logic stop);
    if (stop && p[2]) return 5'b00001;
    if (drx)          return 5'b00010;
    if (dtx)          return 5'b00100;
    if (p[2])         return 5'b00001;
    if (p[1])         return 5'b01000;
    if (p[0])         return 5'b10000;
    return 5'b00000;
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [7:0] wd, input logic [2:0] ev,
                      input logic en, input logic [NF-1:0] fl, input logic drx,
                      input logic dtx, input logic stop, input string tag);
    logic [4:0] eg;
    logic ei;
    logic [2:0] el;
    logic [2:0] np;
    @(negedge clk);
    wr_en = wr; wr_data = wd; {ev_err, ev_rx, ev_tx} = ev; int_en = en;
    err_flags = fl; dma_rx_req = drx; dma_tx_req = dtx; dma_stop = stop;
    eg = exp_grant(m_pend, drx, dtx, stop);
    ei = (|m_pend) && (m_lvl != 3'd7);
    el = m_lvl;
    for (int i = 0; i < 3; i++)
      np[i] = (ev[i] && en) || (m_pend[i] && !(wr && !wd[i]));
    if (|fl) np[2] = 1'b1;
    m_pend = np;
    if (wr) m_lvl = wd[6:4];
    @(posedge clk);
    #1;
    check8(tag, rd_data, {1'b1, m_lvl, 1'b0, m_pend});
    check8(stop ? "R8 grant" : "R9 grant", {3'b0, grant}, {3'b0, eg});
    check8("R7 irq", {7'b0, irq}, {7'b0, ei});
    check8("R7 level", {5'b0, irq_level}, {5'b0, el});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int sd;
    sd = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check8("R1 reset rd", rd_data, 8'hF0);
    check8("R10 reset grant", {3'b0, grant}, 8'h00);
    // R4: all-ones write sets nothing; R1 fixed bits
    step(1, 8'hFF, 3'b000, 1, '0, 0, 0, 1, "R4 R1 write ones");
    // R2: level 3, bits 7/3 written with 0/1 ignored
    step(1, 8'h3D, 3'b000, 1, '0, 0, 0, 1, "R2 level write");
    // R3: disabled events
    step(0, 8'h00, 3'b111, 0, '0, 0, 0, 1, "R3 int_en low");
    step(0, 8'h00, 3'b011, 1, '0, 0, 0, 1, "R3 events set");
    step(0, 8'h00, 3'b000, 1, '0, 0, 0, 0, "R3 hold");
    step(0, 8'h00, 3'b000, 1, '0, 0, 0, 0, "R7 R10 rx int wins");
    // R4: clear only rx
    step(1, 8'h35, 3'b000, 1, '0, 0, 0, 1, "R4 clear rx only");
    // R5: flag pins error bit against clears
    step(1, 8'h31, 3'b000, 0, 8'h10, 0, 0, 1, "R5 flag forces err");
    step(1, 8'h31, 3'b000, 0, 8'h01, 0, 0, 1, "R5 clear lost");
    step(1, 8'h31, 3'b000, 0, 8'h00, 1, 1, 1, "R5 clear after flags");
    step(0, 8'h00, 3'b100, 1, '0, 1, 1, 1, "R8 err event");
    step(0, 8'h00, 3'b000, 1, '0, 1, 1, 1, "R8 err above dma");
    step(0, 8'h00, 3'b000, 1, '0, 1, 1, 0, "R9 dma rx above err");
    step(0, 8'h00, 3'b000, 1, '0, 0, 1, 0, "R9 dma tx above err");
    step(0, 8'h00, 3'b000, 1, '0, 0, 0, 0, "R9 err above ints");
    // R6: event and clear together on tx
    step(1, 8'h3E, 3'b001, 1, '0, 0, 0, 1, "R6 event beats clear");
    step(1, 8'h7F, 3'b000, 1, '0, 0, 0, 1, "R7 level none");
    step(0, 8'h00, 3'b000, 1, '0, 0, 0, 1, "R7 no irq at 7");
    step(1, 8'h08, 3'b000, 1, '0, 0, 0, 1, "R4 clear all");
    step(0, 8'h00, 3'b000, 1, '0, 0, 0, 0, "R10 idle grant zero");
    for (int n = 0; n < 3000; n++) begin
      logic [NF-1:0] fl;
      fl = (($urandom % 8) == 0) ? NF'($urandom) : '0;
      step(($urandom % 3) == 0, 8'($urandom), 3'($urandom), ($urandom % 4) != 0, fl,
           ($urandom % 4) == 0, ($urandom % 4) == 0, 1'($urandom),
           "R3 R4 R5 R6 random");
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule